// File: doc/BRIEF.md
# CAN Controller Host Register Block

This block is the byte-wide host-side register file of a CAN controller that runs with its extended register set. A host reaches it through a small read/write strobe interface. It holds the operating mode, the interrupt enable mask, a clock-divider byte, a status byte and an interrupt flag byte. Writes to the command location do not store anything. They produce single-cycle pulses for transmit request, receive-buffer release and overrun clear.

The receive FIFO, the transmitter and the acceptance filter sit outside the block. They report to it through event strobes and a message count. In return, the block gives them the transmit-buffer write port, the acceptance bytes and the receive-window offset.

A thirteen-byte window starting at address 16 changes meaning with the reset-mode bit:
- In reset mode, the first eight bytes of the window hold acceptance code and mask storage.
- In operating mode, writes to the window go to the transmit buffer, and reads from it return the receive window.

A single level interrupt output is high while any enabled flag is set. Reading the interrupt register clears its flags. The receive flag comes back at once if messages are still waiting.

Top module: `can_host_regs`

## Requirements
- R1: After synchronous reset, mode reads 0x01, status reads 0x3C, the interrupt flags and the clock-divider byte (address 31) read 0x00, and `irq` is low.
- R2: `irq` is high exactly when the interrupt enable byte (address 4) ANDed with the interrupt flags is non-zero. It takes its new value on the same edge as the flag or enable change.
- R3: A read of address 3 returns the flags as they were before the read and clears them. Flag bit 0 (receive) is set again on that edge when `rx_msg_cnt` is non-zero.
- R4: A write to address 1 produces one-cycle pulses on the cycle after the write: `cmd_tx_req` for data bit 0, `cmd_rel_rx` for bit 2 and `cmd_clr_ovr` for bit 3. Bit 3 also clears status bit 1 and flag bit 3. Address 1 reads 0x00.
- R5: `tx_done` sets status bits 2 and 3, clears status bit 5 and sets flag bit 1. A transmit request command clears status bits 2 and 3.
- R6: Status bit 4 is set by `rx_start` and cleared by `rx_end`. Status bit 0 mirrors a non-zero `rx_msg_cnt`. `rx_stored` sets flag bit 0. `rx_overrun` sets status bit 1 and flag bit 3.
- R7: In reset mode (mode bit 0 = 1), addresses 16..23 read and write acceptance bytes 0..7, presented on `acc_bytes` with byte k at bits 8k+7..8k. Addresses 24..28 read 0x00.
- R8: In operating mode, a write at 16..28 pulses `tx_buf_we` one cycle later, with `tx_buf_idx` = address−16 and the written byte. A read there returns `rx_win_data` for `rx_win_ofs` = address−16. No transmit-buffer write happens in reset mode.
- R9: A write to address 16 in operating mode sets status bit 5.
- R10: The mode register stores only data bits 4..0. `single_filter` reflects mode bit 3.
- R11: Unused in-map addresses read 0x00. Addresses 32 and above read 0xFF. Writes to status (address 2) and flags (address 3) are ignored.
- R12: `rdata` is registered. It is valid on the cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tx_done | input | 1 | Transmission completed event |
| rx_start | input | 1 | Incoming frame processing started |
| rx_end | input | 1 | Incoming frame stored, rejected or dropped |
| rx_stored | input | 1 | Frame stored in receive FIFO |
| rx_overrun | input | 1 | Receive FIFO overrun event |
| rx_msg_cnt | input | CNT_W | Messages held in receive FIFO |
| rx_win_ofs | output | WIN_W | Receive window byte offset |
| rx_win_data | input | 8 | Receive window byte at that offset |
| cmd_tx_req | output | 1 | Transmit request pulse |
| cmd_rel_rx | output | 1 | Release receive buffer pulse |
| cmd_clr_ovr | output | 1 | Clear overrun pulse |
| tx_buf_we | output | 1 | Transmit buffer write strobe |
| tx_buf_idx | output | WIN_W | Transmit buffer byte index |
| tx_buf_data | output | 8 | Transmit buffer write byte |
| acc_bytes | output | 8*ACC_BYTES | Acceptance code/mask bytes |
| reg_mode | output | 5 | Mode register |
| single_filter | output | 1 | Single-filter mode select |
| irq | output | 1 | Level interrupt |

## Verification
Every result lands exactly one clock edge after its cause:
- a read's `rdata`;
- the command pulses and the transmit-buffer strobe after a write;
- status, flags and `irq` after an event strobe or a register write.

The bench drives strobes for one full cycle between falling edges. It samples on the falling edge right after the capturing rising edge. For pulses, it checks again one cycle later to confirm they have dropped. Clear-on-read is probed with back-to-back reads, so the second read shows whether the receive flag was re-armed by the non-zero message count.

// File: rtl/chr_pkg.sv
`timescale 1ns/1ps
package chr_pkg;
  // register addresses (host map)
  localparam int A_MODE = 0;
  localparam int A_CMD  = 1;
  localparam int A_STS  = 2;
  localparam int A_FLG  = 3;
  localparam int A_IEN  = 4;
  localparam int A_CLK  = 31;
  // reset values
  localparam logic [4:0] MODE_INIT = 5'h01;
  localparam logic [7:0] STS_INIT  = 8'h3C;
  // status bit positions
  localparam int S_RXBUF = 0;
  localparam int S_OVR   = 1;
  localparam int S_TXCMP = 2;
  localparam int S_TXFREE = 3;
  localparam int S_RXING = 4;
  localparam int S_TXING = 5;
  // flag bit positions
  localparam int F_RX  = 0;
  localparam int F_TX  = 1;
  localparam int F_OVR = 3;
  // command bit positions
  localparam int C_TX  = 0;
  localparam int C_REL = 2;
  localparam int C_CLR = 3;
endpackage

// File: rtl/chr_wr_decode.sv
`timescale 1ns/1ps
module chr_wr_decode #(
  parameter int ADDR_W    = 6,
  parameter int WIN_BASE  = 16,
  parameter int WIN_LEN   = 13,
  parameter int ACC_BYTES = 8,
  localparam int WIN_W    = $clog2(WIN_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic                 reset_mode,
  output logic                 in_win,
  output logic [WIN_W-1:0]     win_ofs,
  output logic                 mode_we,
  output logic                 ien_we,
  output logic                 clk_we,
  output logic [ACC_BYTES-1:0] acc_we,
  output logic                 win_first,
  output logic                 tx_req_now,
  output logic                 clr_ovr_now,
  output logic                 cmd_tx_req,
  output logic                 cmd_rel_rx,
  output logic                 cmd_clr_ovr,
  output logic                 tx_buf_we,
  output logic [WIN_W-1:0]     tx_buf_idx,
  output logic [7:0]           tx_buf_data
);
  import chr_pkg::*;

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + WIN_LEN);

  logic cmd_wr, win_wr;

  assign in_win  = (addr >= WIN_LO) && (addr < WIN_HI);
  assign win_ofs = WIN_W'(addr - WIN_LO);

  assign cmd_wr      = wr_en && (addr == ADDR_W'(A_CMD));
  assign mode_we     = wr_en && (addr == ADDR_W'(A_MODE));
  assign ien_we      = wr_en && (addr == ADDR_W'(A_IEN));
  assign clk_we      = wr_en && (addr == ADDR_W'(A_CLK));
  assign win_wr      = wr_en && in_win && !reset_mode;
  assign win_first   = win_wr && (addr == WIN_LO);
  assign tx_req_now  = cmd_wr && wdata[C_TX];
  assign clr_ovr_now = cmd_wr && wdata[C_CLR];

  for (genvar g = 0; g < ACC_BYTES; g++) begin : g_acc_we
    assign acc_we[g] = wr_en && reset_mode && in_win && (win_ofs == WIN_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_tx_req  <= 1'b0;
      cmd_rel_rx  <= 1'b0;
      cmd_clr_ovr <= 1'b0;
      tx_buf_we   <= 1'b0;
      tx_buf_idx  <= '0;
      tx_buf_data <= '0;
    end else begin
      cmd_tx_req  <= tx_req_now;
      cmd_rel_rx  <= cmd_wr && wdata[C_REL];
      cmd_clr_ovr <= clr_ovr_now;
      tx_buf_we   <= win_wr;
      if (win_wr) begin
        tx_buf_idx  <= win_ofs;
        tx_buf_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/chr_stat_irq.sv
`timescale 1ns/1ps
module chr_stat_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] ien_next,
  input  logic       flg_read,
  input  logic       clr_ovr,
  input  logic       tx_req,
  input  logic       win_first,
  input  logic       tx_done,
  input  logic       rx_start,
  input  logic       rx_end,
  input  logic       rx_stored,
  input  logic       rx_overrun,
  input  logic       msg_nz,
  output logic [7:0] sts_q,
  output logic [7:0] flg_q,
  output logic       irq
);
  import chr_pkg::*;

  logic [7:0] sts_n, flg_n;

  // flags: read-clear first, then set events win over clears
  always_comb begin
    flg_n = flg_q;
    if (flg_read) flg_n = {7'b0, msg_nz};
    if (clr_ovr)  flg_n[F_OVR] = 1'b0;
    if (tx_done)  flg_n[F_TX]  = 1'b1;
    if (rx_stored) flg_n[F_RX] = 1'b1;
    if (rx_overrun) flg_n[F_OVR] = 1'b1;
  end

  always_comb begin
    sts_n = sts_q;
    sts_n[S_RXBUF] = msg_nz;
    if (clr_ovr)    sts_n[S_OVR] = 1'b0;
    if (rx_overrun) sts_n[S_OVR] = 1'b1;
    if (tx_req) begin
      sts_n[S_TXCMP]  = 1'b0;
      sts_n[S_TXFREE] = 1'b0;
    end
    if (tx_done) begin
      sts_n[S_TXCMP]  = 1'b1;
      sts_n[S_TXFREE] = 1'b1;
      sts_n[S_TXING]  = 1'b0;
    end
    if (win_first) sts_n[S_TXING] = 1'b1;
    if (rx_start)  sts_n[S_RXING] = 1'b1;
    if (rx_end)    sts_n[S_RXING] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= STS_INIT;
      flg_q <= 8'h00;
      irq   <= 1'b0;
    end else begin
      sts_q <= sts_n;
      flg_q <= flg_n;
      irq   <= |(ien_next & flg_n);
    end
  end
endmodule

// File: rtl/chr_acc_store.sv
`timescale 1ns/1ps
module chr_acc_store #(
  parameter int ACC_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ACC_BYTES-1:0]     acc_we,
  input  logic [7:0]               wdata,
  output logic [8*ACC_BYTES-1:0]   acc_bytes
);
  for (genvar g = 0; g < ACC_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)            byte_q <= 8'h00;
      else if (acc_we[g]) byte_q <= wdata;
    end
    assign acc_bytes[8*g +: 8] = byte_q;
  end
endmodule

// File: rtl/can_host_regs.sv
`timescale 1ns/1ps
module can_host_regs #(
  parameter int ADDR_W    = 6,
  parameter int MAP_SIZE  = 32,
  parameter int WIN_BASE  = 16,
  parameter int WIN_LEN   = 13,
  parameter int ACC_BYTES = 8,
  parameter int CNT_W     = 7,
  localparam int WIN_W    = $clog2(WIN_LEN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic                   tx_done,
  input  logic                   rx_start,
  input  logic                   rx_end,
  input  logic                   rx_stored,
  input  logic                   rx_overrun,
  input  logic [CNT_W-1:0]       rx_msg_cnt,
  output logic [WIN_W-1:0]       rx_win_ofs,
  input  logic [7:0]             rx_win_data,
  output logic                   cmd_tx_req,
  output logic                   cmd_rel_rx,
  output logic                   cmd_clr_ovr,
  output logic                   tx_buf_we,
  output logic [WIN_W-1:0]       tx_buf_idx,
  output logic [7:0]             tx_buf_data,
  output logic [8*ACC_BYTES-1:0] acc_bytes,
  output logic [4:0]             reg_mode,
  output logic                   single_filter,
  output logic                   irq
);
  import chr_pkg::*;

  localparam int ACC_W = $clog2(ACC_BYTES);

  logic [4:0]           mode_q;
  logic [7:0]           ien_q, clk_q, ien_n;
  logic [7:0]           sts_q, ir_q, rd_val, acc_rd;
  logic                 in_win, mode_we, ien_we, clk_we;
  logic                 win_first, tx_req_now, clr_ovr_now, oor, flg_read;
  logic [WIN_W-1:0]     win_ofs;
  logic [ACC_BYTES-1:0] acc_we;
  logic [7:0]           acc_arr [ACC_BYTES];

  chr_wr_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LEN(WIN_LEN), .ACC_BYTES(ACC_BYTES)
  ) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .reset_mode(mode_q[0]), .in_win(in_win), .win_ofs(win_ofs),
    .mode_we(mode_we), .ien_we(ien_we), .clk_we(clk_we), .acc_we(acc_we),
    .win_first(win_first), .tx_req_now(tx_req_now), .clr_ovr_now(clr_ovr_now),
    .cmd_tx_req(cmd_tx_req), .cmd_rel_rx(cmd_rel_rx), .cmd_clr_ovr(cmd_clr_ovr),
    .tx_buf_we(tx_buf_we), .tx_buf_idx(tx_buf_idx), .tx_buf_data(tx_buf_data)
  );

  assign oor      = addr >= ADDR_W'(MAP_SIZE);
  assign flg_read = rd_en && !oor && (addr == ADDR_W'(A_FLG));
  assign ien_n    = ien_we ? wdata : ien_q;

  chr_stat_irq u_si (
    .clk(clk), .rst(rst), .ien_next(ien_n), .flg_read(flg_read),
    .clr_ovr(clr_ovr_now), .tx_req(tx_req_now), .win_first(win_first),
    .tx_done(tx_done), .rx_start(rx_start), .rx_end(rx_end),
    .rx_stored(rx_stored), .rx_overrun(rx_overrun),
    .msg_nz(rx_msg_cnt != '0), .sts_q(sts_q), .flg_q(ir_q), .irq(irq)
  );

  chr_acc_store #(.ACC_BYTES(ACC_BYTES)) u_acc (
    .clk(clk), .rst(rst), .acc_we(acc_we), .wdata(wdata), .acc_bytes(acc_bytes)
  );

  for (genvar g = 0; g < ACC_BYTES; g++) begin : g_unpack
    assign acc_arr[g] = acc_bytes[8*g +: 8];
  end
  assign acc_rd = acc_arr[win_ofs[ACC_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_INIT;
      ien_q  <= 8'h00;
      clk_q  <= 8'h00;
    end else begin
      if (mode_we) mode_q <= wdata[4:0];
      ien_q <= ien_n;
      if (clk_we)  clk_q  <= wdata;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (oor) begin
      rd_val = 8'hFF;
    end else if (in_win) begin
      if (!mode_q[0])                       rd_val = rx_win_data;
      else if (win_ofs < WIN_W'(ACC_BYTES)) rd_val = acc_rd;
    end else begin
      case (addr)
        ADDR_W'(A_MODE): rd_val = {3'b000, mode_q};
        ADDR_W'(A_STS):  rd_val = sts_q;
        ADDR_W'(A_FLG):  rd_val = ir_q;
        ADDR_W'(A_IEN):  rd_val = ien_q;
        ADDR_W'(A_CLK):  rd_val = clk_q;
        default:         rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= rd_val;
  end

  assign rx_win_ofs    = win_ofs;
  assign reg_mode      = mode_q;
  assign single_filter = mode_q[3];
endmodule

// File: rtl/chr_regs_chk.sv
`timescale 1ns/1ps
module chr_regs_chk #(
  parameter int ADDR_W   = 6,
  parameter int MAP_SIZE = 32,
  parameter int CNT_W    = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              tx_done,
  input logic [CNT_W-1:0]  rx_msg_cnt,
  input logic              cmd_tx_req,
  input logic              tx_buf_we,
  input logic [4:0]        reg_mode,
  input logic [7:0]        ir_q
);
  p_tx_flag_r5: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> ir_q[1]);

  p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_tx_req |-> ($past(wr_en) && $past(addr) == ADDR_W'(1) && $past(wdata[0])));

  p_cmd_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(1)) |=> rdata == 8'h00);

  p_out_of_map_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= ADDR_W'(MAP_SIZE)) |=> rdata == 8'hFF);

  p_mode_width_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(0)) |=> rdata[7:5] == 3'b000);

  p_txbuf_operating_r8: assert property (@(posedge clk) disable iff (rst)
    tx_buf_we |-> !$past(reg_mode[0]));

  p_rx_rearm_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(3) && rx_msg_cnt != '0) |=> ir_q[0]);

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind can_host_regs chr_regs_chk #(
  .ADDR_W(ADDR_W), .MAP_SIZE(MAP_SIZE), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .tx_done(tx_done), .rx_msg_cnt(rx_msg_cnt),
  .cmd_tx_req(cmd_tx_req), .tx_buf_we(tx_buf_we), .reg_mode(reg_mode),
  .ir_q(ir_q)
);

// File: tb/can_host_regs_test.sv
`timescale 1ns/1ps
module can_host_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        tx_done = 0, rx_start = 0, rx_end = 0, rx_stored = 0, rx_overrun = 0;
  logic [6:0]  rx_msg_cnt = '0;
  logic [3:0]  rx_win_ofs, tx_buf_idx;
  logic [7:0]  rx_win_data, tx_buf_data;
  logic        cmd_tx_req, cmd_rel_rx, cmd_clr_ovr, tx_buf_we, single_filter, irq;
  logic [63:0] acc_bytes;
  logic [4:0]  reg_mode;

  int applied = 0;
  int miscomp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rx_win_data = 8'hC0 | {4'h0, rx_win_ofs};

  can_host_regs uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_done(tx_done), .rx_start(rx_start),
    .rx_end(rx_end), .rx_stored(rx_stored), .rx_overrun(rx_overrun),
    .rx_msg_cnt(rx_msg_cnt), .rx_win_ofs(rx_win_ofs), .rx_win_data(rx_win_data),
    .cmd_tx_req(cmd_tx_req), .cmd_rel_rx(cmd_rel_rx), .cmd_clr_ovr(cmd_clr_ovr),
    .tx_buf_we(tx_buf_we), .tx_buf_idx(tx_buf_idx), .tx_buf_data(tx_buf_data),
    .acc_bytes(acc_bytes), .reg_mode(reg_mode), .single_filter(single_filter),
    .irq(irq)
  );

  // vector: {is_read, req, addr, wdata, expected}
  localparam int NV = 24;
  localparam logic [26:0] VECS [NV] = '{
    {1'b1, 4'd1,  6'd0,  8'h00, 8'h01},  // R1 mode
    {1'b1, 4'd1,  6'd2,  8'h00, 8'h3C},  // R1 status
    {1'b1, 4'd1,  6'd3,  8'h00, 8'h00},  // R1 flags
    {1'b1, 4'd1,  6'd31, 8'h00, 8'h00},  // R1 clock divider
    {1'b0, 4'd7,  6'd16, 8'hAA, 8'h00},
    {1'b0, 4'd7,  6'd23, 8'h55, 8'h00},
    {1'b0, 4'd7,  6'd17, 8'hC3, 8'h00},
    {1'b1, 4'd7,  6'd16, 8'h00, 8'hAA},  // R7
    {1'b1, 4'd7,  6'd23, 8'h00, 8'h55},  // R7
    {1'b1, 4'd7,  6'd24, 8'h00, 8'h00},  // R7 beyond acceptance bytes
    {1'b1, 4'd4,  6'd1,  8'h00, 8'h00},  // R4 command reads zero
    {1'b1, 4'd11, 6'd7,  8'h00, 8'h00},  // R11 unused
    {1'b1, 4'd11, 6'd40, 8'h00, 8'hFF},  // R11 out of map
    {1'b0, 4'd11, 6'd2,  8'hFF, 8'h00},
    {1'b1, 4'd11, 6'd2,  8'h00, 8'h3C},  // R11 status write ignored
    {1'b0, 4'd11, 6'd3,  8'hFF, 8'h00},
    {1'b1, 4'd11, 6'd3,  8'h00, 8'h00},  // R11 flag write ignored
    {1'b0, 4'd10, 6'd0,  8'hE8, 8'h00},
    {1'b1, 4'd10, 6'd0,  8'h00, 8'h08},  // R10 low 5 bits kept
    {1'b0, 4'd2,  6'd4,  8'h03, 8'h00},
    {1'b1, 4'd2,  6'd4,  8'h00, 8'h03},  // R2 enable byte
    {1'b0, 4'd1,  6'd31, 8'h80, 8'h00},
    {1'b1, 4'd1,  6'd31, 8'h00, 8'h80},  // R1 clock divider storage
    {1'b1, 4'd10, 6'd0,  8'h00, 8'h08}   // R10
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_tx_done();
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask
  task automatic pulse_rx_start();
    @(negedge clk); rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
  endtask
  task automatic pulse_rx_end();
    @(negedge clk); rx_end = 1'b1; @(negedge clk); rx_end = 1'b0;
  endtask
  task automatic pulse_rx_stored();
    @(negedge clk); rx_stored = 1'b1; @(negedge clk); rx_stored = 1'b0;
  endtask
  task automatic pulse_rx_overrun();
    @(negedge clk); rx_overrun = 1'b1; @(negedge clk); rx_overrun = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    applied++; miscomp++;
    $display("FAIL watchdog expired, run did not complete");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", irq, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][26]) begin
        do_read(VECS[i][21:16]);
        chk($sformatf("R%0d read addr %0d", VECS[i][25:22], VECS[i][21:16]),
            rdata, VECS[i][7:0]);
      end else begin
        do_write(VECS[i][21:16], VECS[i][15:8]);
      end
    end

    chk("R7 acceptance bytes 0..1", acc_bytes[15:0], 16'hC3AA);
    chk("R7 acceptance byte 7", acc_bytes[63:56], 8'h55);
    chk("R10 single filter", single_filter, 1);
    chk("R2 irq idle", irq, 0);

    // receive/transmit status events (operating mode, enable = 0x03)
    pulse_rx_end();
    do_read(6'd2);  chk("R6 receiving cleared", rdata, 8'h2C);
    pulse_tx_done();
    chk("R2 irq on tx flag", irq, 1);
    do_read(6'd2);  chk("R5 tx done status", rdata, 8'h0C);
    do_read(6'd3);  chk("R3 flags read", rdata, 8'h02);
    chk("R3 irq after clear-on-read", irq, 0);

    do_write(6'd16, 8'h12);
    chk("R8 tx write strobe", tx_buf_we, 1);
    chk("R8 tx index", tx_buf_idx, 0);
    chk("R8 tx data", tx_buf_data, 8'h12);
    do_read(6'd2);  chk("R9 transmitting set", rdata, 8'h2C);
    do_write(6'd28, 8'h77);
    chk("R8 tx index last", tx_buf_idx, 12);
    chk("R8 tx data last", tx_buf_data, 8'h77);
    do_read(6'd20); chk("R8 receive window", rdata, 8'hC4);

    do_write(6'd1, 8'h0D);
    chk("R4 tx request pulse", cmd_tx_req, 1);
    chk("R4 release pulse", cmd_rel_rx, 1);
    chk("R4 clear overrun pulse", cmd_clr_ovr, 1);
    @(negedge clk);
    chk("R4 pulse width", {cmd_tx_req, cmd_rel_rx, cmd_clr_ovr}, 0);
    do_read(6'd2);  chk("R5 request clears complete", rdata, 8'h20);

    pulse_rx_overrun();
    chk("R2 masked overrun", irq, 0);
    do_read(6'd2);  chk("R6 overrun status", rdata, 8'h22);
    do_write(6'd4, 8'h08);
    chk("R2 irq on enable", irq, 1);
    do_write(6'd1, 8'h08);
    chk("R4 only clear pulse", {cmd_tx_req, cmd_clr_ovr}, 2'b01);
    chk("R4 irq after overrun clear", irq, 0);
    do_read(6'd2);  chk("R4 overrun status cleared", rdata, 8'h20);

    pulse_rx_start();
    do_read(6'd2);  chk("R6 receiving set", rdata, 8'h30);
    pulse_rx_end();

    rx_msg_cnt = 7'd2;
    pulse_rx_stored();
    do_write(6'd4, 8'h01);
    chk("R2 irq receive", irq, 1);
    do_read(6'd2);  chk("R6 buffer status", rdata, 8'h21);
    do_read(6'd3);  chk("R3 first read", rdata, 8'h01);
    do_read(6'd3);  chk("R3 rearmed", rdata, 8'h01);
    chk("R3 irq held", irq, 1);
    rx_msg_cnt = 7'd0;
    do_read(6'd3);  chk("R3 last rearmed read", rdata, 8'h01);
    do_read(6'd3);  chk("R3 cleared", rdata, 8'h00);
    chk("R2 irq dropped", irq, 0);

    do_write(6'd0, 8'h01);
    do_write(6'd18, 8'h33);
    chk("R8 no tx write in reset mode", tx_buf_we, 0);
    do_read(6'd18); chk("R7 acceptance byte 2", rdata, 8'h33);
    chk("R7 acceptance out", acc_bytes[23:16], 8'h33);
    repeat (2) @(negedge clk);
    chk("R12 rdata hold", rdata, 8'h33);
    do_read(6'd0);  chk("R10 mode back to reset", rdata, 8'h01);

    report();
  end
endmodule